// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits on the write path of a byte-wide non-volatile memory. It sees each bus write (address and data) and tracks the keyed write sequences that guard the array. There are two families of sequence. A three-step sequence is a two-write key followed by a command byte. A six-step sequence is the key, an extension byte, the key again and a final command byte. Together they raise and drop a persistent write-protect flag, open a page-load window, start a chip erase and enter or leave an identification mode. Writes that are plain data reach the page buffer through a registered forward port. While protection is on, that forward port is closed except inside a page-load window. The window opens only through the three-step sequence.

Erase is only a start pulse and a busy level that lasts a fixed number of cycles; the erase timer downstream does the work. While identification mode is active, reads of the two lowest addresses return fixed vendor and device bytes in place of array data. The protect flag has its own power-on reset input, so a soft reset of the block leaves it untouched.

The sequencer is a named state machine. The states are IDLE, KEY1 (first key byte seen), KEY2 (key complete), EXT3 (extension byte seen), EXT4 and EXT5 (second key in progress or complete), and LOAD (page-load window open). Transitions:
- IDLE to KEY1 on AAh at 5555h. KEY1 to KEY2 on 55h at 2AAAh.
- KEY2 on a write to 5555h: A0h goes to LOAD and sets protection, 80h goes to EXT3, F0h goes to IDLE and leaves identification mode.
- EXT3 to EXT4 on AAh at 5555h. EXT4 to EXT5 on 55h at 2AAAh.
- EXT5 on a write to 5555h goes to IDLE: 20h clears protection, 10h starts erase, 60h enters identification mode.
- LOAD to IDLE after a run of write-free cycles.
- Any other write from a key or extension state goes to RESTART: it is judged again as if it had arrived in IDLE.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: Power-on reset (por_n and rst_n low) leaves prot_on=1, id_mode=0, load_open=0, erase_busy=0, arr_we=0. A soft reset (rst_n low alone) clears all of these except prot_on, which keeps its value.
- R2: The key is AAh written to 5555h, then 55h written to 2AAAh. Only wr_addr[14:0] is compared, so bit 16 is ignored, and any other address (such as 5554h) breaks the key.
- R3: Key plus A0h at 5555h sets prot_on and raises load_open. Every write while load_open is high is forwarded. load_open falls after LOAD_GAP consecutive write-free cycles; any write restarts that count.
- R4: While prot_on=1 and load_open=0, no write is forwarded: arr_we stays 0.
- R5: While prot_on=0, a write that is not a sequence step is forwarded: arr_we pulses one cycle after the write, with the same address and data.
- R6: Key, 80h at 5555h, key, 20h at 5555h clears prot_on.
- R7: The same six steps ending in 10h give a one-cycle erase_start together with the rise of erase_busy. erase_busy stays high for exactly ERASE_CYCLES cycles, and writes seen while it is high are ignored.
- R8: The six steps ending in 60h set id_mode; key plus F0h at 5555h clears it.
- R9: A read gives rd_valid and rd_data one cycle after rd_en. With id_mode=1, address 0 returns DAh and address 1 returns C1h. Every other case returns arr_rd_data.
- R10: A write that does not match the expected step returns the sequencer to IDLE and is evaluated as a first step. AAh at 5555h starts a new key; anything else is forwarded only when unprotected.
- R11: Writes consumed as sequence steps are never forwarded.
- R12: prot_on and id_mode change only in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Soft reset, active low, async |
| por_n | input | 1 | Power-on reset, active low, async; the only reset of the protect flag |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Read address |
| arr_rd_data | input | 8 | Array data for rd_addr, same cycle |
| arr_we | output | 1 | Forwarded write strobe to the page buffer |
| arr_addr | output | ADDR_W | Forwarded write address |
| arr_data | output | 8 | Forwarded write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| prot_on | output | 1 | Write protection active |
| id_mode | output | 1 | Identification mode active |
| load_open | output | 1 | Page-load window open |
| erase_start | output | 1 | One-cycle erase start |
| erase_busy | output | 1 | Erase in progress |

## Verification
The bench builds the block with LOAD_GAP=6 and ERASE_CYCLES=20, against the default values of 37,500 and 6,250,000. These lengths put the close of the page-load window, and the full erase busy period including the last busy cycle, within a few dozen cycles of stimulus. Random writes drawn from the command alphabet can then run complete sequences, aborted ones and erases many times over in one short run. The address width stays at its default of 17, so the ignored bit 16 can be exercised.

// File: rtl/unlock_cmd_pkg.sv
package unlock_cmd_pkg;

    localparam int DATA_W = 8;
    localparam int CMP_W  = 15;

    localparam logic [CMP_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [CMP_W-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [DATA_W-1:0] KEY_BYTE_A  = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_BYTE_B  = 8'h55;
    localparam logic [DATA_W-1:0] CMD_LOAD    = 8'hA0;
    localparam logic [DATA_W-1:0] CMD_EXTEND  = 8'h80;
    localparam logic [DATA_W-1:0] CMD_ID_EXIT = 8'hF0;
    localparam logic [DATA_W-1:0] CMD_UNPROT  = 8'h20;
    localparam logic [DATA_W-1:0] CMD_ERASE   = 8'h10;
    localparam logic [DATA_W-1:0] CMD_ID_ENTR = 8'h60;

    localparam logic [DATA_W-1:0] ID_VENDOR = 8'hDA;
    localparam logic [DATA_W-1:0] ID_DEVICE = 8'hC1;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_KEY1 = 3'd1,
        S_KEY2 = 3'd2,
        S_EXT3 = 3'd3,
        S_EXT4 = 3'd4,
        S_EXT5 = 3'd5,
        S_LOAD = 3'd6
    } seq_state_t;

endpackage

// File: rtl/unlock_seq_fsm.sv
module unlock_seq_fsm
    import unlock_cmd_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int LOAD_GAP = 37500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              prot_on,
    input  logic              erase_busy,
    output logic              fwd_we,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [DATA_W-1:0] fwd_data,
    output logic              load_open,
    output logic              set_prot,
    output logic              clr_prot,
    output logic              set_id,
    output logic              clr_id,
    output logic              erase_go
);

    localparam int GAP_W = (LOAD_GAP > 1) ? $clog2(LOAD_GAP + 1) : 1;
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(LOAD_GAP - 1);

    seq_state_t       state_q, state_d;
    logic [GAP_W-1:0] gap_q, gap_d;
    logic             fwd_c;

    logic [CMP_W-1:0] cmp_addr;
    logic             at_a, at_b, is_first, is_second;
    seq_state_t       restart_state;
    logic             restart_fwd;

    assign cmp_addr  = wr_addr[CMP_W-1:0];
    assign at_a      = (cmp_addr == KEY_ADDR_A);
    assign at_b      = (cmp_addr == KEY_ADDR_B);
    assign is_first  = at_a && (wr_data == KEY_BYTE_A);
    assign is_second = at_b && (wr_data == KEY_BYTE_B);

    // A write that breaks a sequence is judged as if it came in IDLE.
    assign restart_state = is_first ? S_KEY1 : S_IDLE;
    assign restart_fwd   = !is_first && !prot_on;

    always_comb begin
        state_d  = state_q;
        gap_d    = gap_q;
        fwd_c    = 1'b0;
        set_prot = 1'b0;
        clr_prot = 1'b0;
        set_id   = 1'b0;
        clr_id   = 1'b0;
        erase_go = 1'b0;
        if (!erase_busy) begin
            unique case (state_q)
                S_IDLE: begin
                    if (wr_en) begin
                        state_d = restart_state;
                        fwd_c   = restart_fwd;
                    end
                end
                S_KEY1: begin
                    if (wr_en) begin
                        if (is_second) begin
                            state_d = S_KEY2;
                        end else begin
                            state_d = restart_state;
                            fwd_c   = restart_fwd;
                        end
                    end
                end
                S_KEY2: begin
                    if (wr_en) begin
                        if (at_a && wr_data == CMD_LOAD) begin
                            state_d  = S_LOAD;
                            gap_d    = '0;
                            set_prot = 1'b1;
                        end else if (at_a && wr_data == CMD_EXTEND) begin
                            state_d = S_EXT3;
                        end else if (at_a && wr_data == CMD_ID_EXIT) begin
                            state_d = S_IDLE;
                            clr_id  = 1'b1;
                        end else begin
                            state_d = restart_state;
                            fwd_c   = restart_fwd;
                        end
                    end
                end
                S_EXT3: begin
                    if (wr_en) begin
                        if (is_first) begin
                            state_d = S_EXT4;
                        end else begin
                            state_d = restart_state;
                            fwd_c   = restart_fwd;
                        end
                    end
                end
                S_EXT4: begin
                    if (wr_en) begin
                        if (is_second) begin
                            state_d = S_EXT5;
                        end else begin
                            state_d = restart_state;
                            fwd_c   = restart_fwd;
                        end
                    end
                end
                S_EXT5: begin
                    if (wr_en) begin
                        if (at_a && wr_data == CMD_UNPROT) begin
                            state_d  = S_IDLE;
                            clr_prot = 1'b1;
                        end else if (at_a && wr_data == CMD_ERASE) begin
                            state_d  = S_IDLE;
                            erase_go = 1'b1;
                        end else if (at_a && wr_data == CMD_ID_ENTR) begin
                            state_d = S_IDLE;
                            set_id  = 1'b1;
                        end else begin
                            state_d = restart_state;
                            fwd_c   = restart_fwd;
                        end
                    end
                end
                S_LOAD: begin
                    if (wr_en) begin
                        fwd_c = 1'b1;
                        gap_d = '0;
                    end else if (gap_q == GAP_LAST) begin
                        state_d = S_IDLE;
                        gap_d   = '0;
                    end else begin
                        gap_d = gap_q + 1'b1;
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_we   <= 1'b0;
            fwd_addr <= '0;
            fwd_data <= '0;
        end else begin
            fwd_we <= fwd_c;
            if (fwd_c) begin
                fwd_addr <= wr_addr;
                fwd_data <= wr_data;
            end
        end
    end

    assign load_open = (state_q == S_LOAD);

endmodule

// File: rtl/unlock_mode_flags.sv
module unlock_mode_flags (
    input  logic clk,
    input  logic por_n,
    input  logic id_rst_n,
    input  logic set_prot,
    input  logic clr_prot,
    input  logic set_id,
    input  logic clr_id,
    output logic prot_on,
    output logic id_mode
);

    // Protect flag: only power-on reset touches it.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            prot_on <= 1'b1;
        end else if (set_prot) begin
            prot_on <= 1'b1;
        end else if (clr_prot) begin
            prot_on <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge id_rst_n) begin
        if (!id_rst_n) begin
            id_mode <= 1'b0;
        end else if (set_id) begin
            id_mode <= 1'b1;
        end else if (clr_id) begin
            id_mode <= 1'b0;
        end
    end

endmodule

// File: rtl/unlock_erase_timer.sv
module unlock_erase_timer #(
    parameter int ERASE_CYCLES = 6250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic erase_go,
    output logic erase_start,
    output logic erase_busy
);

    localparam int CNT_W = (ERASE_CYCLES > 1) ? $clog2(ERASE_CYCLES + 1) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ERASE_CYCLES - 1);

    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            erase_busy  <= 1'b0;
            erase_start <= 1'b0;
            left_q      <= '0;
        end else begin
            erase_start <= erase_go;
            if (erase_go) begin
                erase_busy <= 1'b1;
                left_q     <= CNT_LOAD;
            end else if (erase_busy) begin
                if (left_q == '0) begin
                    erase_busy <= 1'b0;
                end else begin
                    left_q <= left_q - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/unlock_id_read.sv
module unlock_id_read
    import unlock_cmd_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_rd_data,
    input  logic              id_mode,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [ADDR_W-1:0] ID_ADDR_VENDOR = '0;
    localparam logic [ADDR_W-1:0] ID_ADDR_DEVICE = ADDR_W'(1);

    logic [DATA_W-1:0] pick;

    always_comb begin
        pick = arr_rd_data;
        if (id_mode && rd_addr == ID_ADDR_VENDOR) begin
            pick = ID_VENDOR;
        end else if (id_mode && rd_addr == ID_ADDR_DEVICE) begin
            pick = ID_DEVICE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= pick;
            end
        end
    end

endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
    import unlock_cmd_pkg::*;
#(
    parameter int ADDR_W       = 17,
    parameter int LOAD_GAP     = 37500,
    parameter int ERASE_CYCLES = 6250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        arr_rd_data,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_data,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              prot_on,
    output logic              id_mode,
    output logic              load_open,
    output logic              erase_start,
    output logic              erase_busy
);

    logic set_prot, clr_prot, set_id, clr_id, erase_go;
    logic core_rst_n;

    // Power-on reset also resets everything the soft reset covers.
    assign core_rst_n = rst_n & por_n;

    unlock_seq_fsm #(
        .ADDR_W   (ADDR_W),
        .LOAD_GAP (LOAD_GAP)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (core_rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .prot_on    (prot_on),
        .erase_busy (erase_busy),
        .fwd_we     (arr_we),
        .fwd_addr   (arr_addr),
        .fwd_data   (arr_data),
        .load_open  (load_open),
        .set_prot   (set_prot),
        .clr_prot   (clr_prot),
        .set_id     (set_id),
        .clr_id     (clr_id),
        .erase_go   (erase_go)
    );

    unlock_mode_flags u_flags (
        .clk      (clk),
        .por_n    (por_n),
        .id_rst_n (core_rst_n),
        .set_prot (set_prot),
        .clr_prot (clr_prot),
        .set_id   (set_id),
        .clr_id   (clr_id),
        .prot_on  (prot_on),
        .id_mode  (id_mode)
    );

    unlock_erase_timer #(
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_erase (
        .clk         (clk),
        .rst_n       (core_rst_n),
        .erase_go    (erase_go),
        .erase_start (erase_start),
        .erase_busy  (erase_busy)
    );

    unlock_id_read #(
        .ADDR_W (ADDR_W)
    ) u_read (
        .clk         (clk),
        .rst_n       (core_rst_n),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .arr_rd_data (arr_rd_data),
        .id_mode     (id_mode),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/unlock_cmd_decoder_chk.sv
module unlock_cmd_decoder_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              arr_we,
    input logic [7:0]        rd_data,
    input logic              rd_valid,
    input logic              prot_on,
    input logic              id_mode,
    input logic              load_open,
    input logic              erase_start,
    input logic              erase_busy
);

    AST_BUSY_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (erase_busy && wr_en) |=> !arr_we); // R7

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        erase_start |=> !erase_start); // R7

    AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        erase_start |-> (erase_busy && !$past(erase_busy))); // R7

    AST_PROT_GATES_ARRAY: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        arr_we |-> (load_open || !$past(prot_on))); // R4

    AST_PROT_MOVES_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !$past(wr_en) |-> $stable(prot_on)); // R12

    AST_ID_MOVES_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !$past(wr_en) |-> $stable(id_mode)); // R8

    AST_ID_VENDOR_BYTE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $past(rd_en && id_mode && rd_addr == '0) |-> (rd_valid && rd_data == 8'hDA)); // R9

    AST_LOAD_NOT_ERASING: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !(load_open && erase_busy)); // R3

endmodule

bind unlock_cmd_decoder unlock_cmd_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_n       (por_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .arr_we      (arr_we),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .prot_on     (prot_on),
    .id_mode     (id_mode),
    .load_open   (load_open),
    .erase_start (erase_start),
    .erase_busy  (erase_busy)
);

// File: tb/unlock_cmd_decoder_test.sv
`timescale 1ns/1ps
module unlock_cmd_decoder_test;

    localparam int AW = 17;
    localparam int LG = 6;
    localparam int EC = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0, por_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0]    wr_data = '0, arr_rd_data;
    logic          arr_we, rd_valid, prot_on, id_mode, load_open, erase_start, erase_busy;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_data, rd_data;

    int n_chk = 0, n_fail = 0;

    // Model state
    int            m_st = 0, m_gap = 0, m_busy = 0;
    bit            m_prot = 1'b1, m_id = 1'b0;
    bit            e_we, e_start, e_rv;
    logic [AW-1:0] e_addr;
    logic [7:0]    e_data, e_rd;

    always #4 clk = ~clk;

    assign arr_rd_data = rd_addr[7:0] ^ 8'h3C;

    unlock_cmd_decoder #(.ADDR_W(AW), .LOAD_GAP(LG), .ERASE_CYCLES(EC)) uut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .arr_rd_data(arr_rd_data),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .prot_on(prot_on), .id_mode(id_mode), .load_open(load_open),
        .erase_start(erase_start), .erase_busy(erase_busy)
    );

    function automatic bit hit(logic [AW-1:0] a, logic [14:0] ka, logic [7:0] d, logic [7:0] kd);
        return (a[14:0] == ka) && (d == kd);
    endfunction

    function automatic logic [7:0] read_expect(logic [AW-1:0] ra, bit idm);
        if (idm && ra == 0) return 8'hDA;
        if (idm && ra == 1) return 8'hC1;
        return ra[7:0] ^ 8'h3C;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Advance the model across one clock edge.
    task automatic model_edge(bit we, logic [AW-1:0] a, logic [7:0] d, bit re, logic [AW-1:0] ra);
        bit busy_b, first;
        busy_b  = (m_busy > 0);
        if (m_busy > 0) m_busy--;
        e_we    = 1'b0;
        e_start = 1'b0;
        e_rv    = re;
        e_rd    = read_expect(ra, m_id);
        first   = hit(a, 15'h5555, d, 8'hAA);
        if (m_st == 6) begin
            if (we) begin
                e_we = 1'b1; e_addr = a; e_data = d; m_gap = 0;
            end else if (m_gap == LG - 1) begin
                m_st = 0; m_gap = 0;
            end else begin
                m_gap++;
            end
        end else if (we && !busy_b) begin
            bit brk;
            brk = 1'b0;
            case (m_st)
                0: brk = 1'b1;
                1: if (hit(a, 15'h2AAA, d, 8'h55)) m_st = 2; else brk = 1'b1;
                2: if (hit(a, 15'h5555, d, 8'hA0)) begin m_st = 6; m_gap = 0; m_prot = 1'b1; end
                   else if (hit(a, 15'h5555, d, 8'h80)) m_st = 3;
                   else if (hit(a, 15'h5555, d, 8'hF0)) begin m_st = 0; m_id = 1'b0; end
                   else brk = 1'b1;
                3: if (first) m_st = 4; else brk = 1'b1;
                4: if (hit(a, 15'h2AAA, d, 8'h55)) m_st = 5; else brk = 1'b1;
                5: if (hit(a, 15'h5555, d, 8'h20)) begin m_st = 0; m_prot = 1'b0; end
                   else if (hit(a, 15'h5555, d, 8'h10)) begin m_st = 0; m_busy = EC; e_start = 1'b1; end
                   else if (hit(a, 15'h5555, d, 8'h60)) begin m_st = 0; m_id = 1'b1; end
                   else brk = 1'b1;
                default: brk = 1'b1;
            endcase
            if (brk) begin
                m_st = first ? 1 : 0;
                if (!first && !m_prot) begin
                    e_we = 1'b1; e_addr = a; e_data = d;
                end
            end
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "arr_we (R4/R5/R11)", arr_we, e_we);
        if (e_we) begin
            chk(tag, "arr_addr (R5)", arr_addr, e_addr);
            chk(tag, "arr_data (R5)", arr_data, e_data);
        end
        chk(tag, "prot_on (R12)", prot_on, m_prot);
        chk(tag, "id_mode (R8)", id_mode, m_id);
        chk(tag, "load_open (R3)", load_open, m_st == 6);
        chk(tag, "erase_busy (R7)", erase_busy, m_busy > 0);
        chk(tag, "erase_start (R7)", erase_start, e_start);
        chk(tag, "rd_valid (R9)", rd_valid, e_rv);
        if (e_rv) chk(tag, "rd_data (R9)", rd_data, e_rd);
    endtask

    task automatic cyc(string tag, bit we, logic [AW-1:0] a, logic [7:0] d, bit re, logic [AW-1:0] ra);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; rd_en = re; rd_addr = ra;
        @(posedge clk);
        model_edge(we, a, d, re, ra);
        #2;
        compare(tag);
    endtask

    task automatic wr(string tag, logic [AW-1:0] a, logic [7:0] d);
        cyc(tag, 1'b1, a, d, 1'b0, '0);
    endtask

    task automatic rd(string tag, logic [AW-1:0] ra);
        cyc(tag, 1'b0, '0, '0, 1'b1, ra);
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) cyc(tag, 1'b0, '0, '0, 1'b0, '0);
    endtask

    task automatic key(string tag);
        wr(tag, 17'h05555, 8'hAA);
        wr(tag, 17'h02AAA, 8'h55);
    endtask

    task automatic six(string tag, logic [7:0] last);
        key(tag);
        wr(tag, 17'h05555, 8'h80);
        key(tag);
        wr(tag, 17'h05555, last);
    endtask

    task automatic do_reset(string tag, bit power);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        rst_n = 1'b0;
        if (power) por_n = 1'b0;
        @(posedge clk);
        #2;
        m_st = 0; m_gap = 0; m_busy = 0; m_id = 1'b0;
        if (power) m_prot = 1'b1;
        e_we = 1'b0; e_start = 1'b0; e_rv = 1'b0;
        compare(tag);
        @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [14:0] pool_a [3];
        logic [7:0]  pool_d [8];
        pool_a = '{15'h5555, 15'h2AAA, 15'h5554};
        pool_d = '{8'hAA, 8'h55, 8'h80, 8'hA0, 8'h20, 8'h10, 8'h60, 8'hF0};
        void'($urandom(32'd1471));

        // R1: power-on state
        do_reset("R1", 1'b1);
        chk("R1", "prot_on after power-on", prot_on, 1'b1);

        // R4: protected plain write dropped
        wr("R4", 17'h01234, 8'h77);
        idle("R4", 1);

        // R3: three-step load, writes in window, window closes after LG idle
        key("R3");
        wr("R3", 17'h05555, 8'hA0);
        wr("R3", 17'h00100, 8'h11);
        idle("R3", 2);
        wr("R3", 17'h00101, 8'h22);
        idle("R3", LG);
        chk("R3", "window closed", load_open, 1'b0);
        wr("R4", 17'h00102, 8'h33);

        // R6 and R2: unprotect, bit 16 set on one step
        key("R6");
        wr("R2", 17'h15555, 8'h80);
        key("R6");
        wr("R6", 17'h05555, 8'h20);
        chk("R6", "protection cleared", prot_on, 1'b0);

        // R5 / R11: plain write forwarded, steps not forwarded
        wr("R5", 17'h1ABCD, 8'h5A);
        key("R11");
        // R10: broken step forwarded when unprotected
        wr("R10", 17'h05555, 8'h33);
        // R2: near-miss address breaks key
        wr("R2", 17'h05555, 8'hAA);
        wr("R2", 17'h02AAB, 8'h55);
        // R10: repeated first byte restarts key, then load
        wr("R10", 17'h05555, 8'hAA);
        wr("R10", 17'h05555, 8'hAA);
        wr("R10", 17'h02AAA, 8'h55);
        wr("R10", 17'h05555, 8'hA0);
        chk("R10", "restarted key opens window", load_open, 1'b1);
        idle("R10", LG);

        // R8 / R9: identification mode
        rd("R9", 17'h00000);
        six("R8", 8'h60);
        rd("R9", 17'h00000);
        rd("R9", 17'h00001);
        rd("R9", 17'h00002);
        rd("R9", 17'h10000);
        key("R8");
        wr("R8", 17'h05555, 8'hF0);
        rd("R9", 17'h00001);

        // R7: erase, writes ignored while busy, exact length
        six("R7", 8'h10);
        key("R7");
        wr("R7", 17'h05555, 8'hA0);
        idle("R7", EC - 4);
        wr("R7", 17'h00042, 8'h42);

        // R1: soft reset keeps protect flag
        six("R1", 8'h60);
        do_reset("R1", 1'b0);
        chk("R1", "soft reset keeps prot", prot_on, m_prot);

        // Random phase, model compared each cycle
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [AW-1:0] a;
            logic [7:0]    d;
            op = int'($urandom_range(0, 9));
            a  = AW'($urandom);
            d  = 8'($urandom);
            if ($urandom_range(0, 3) != 0) a[14:0] = pool_a[$urandom_range(0, 2)];
            if ($urandom_range(0, 4) != 0) d = pool_d[$urandom_range(0, 7)];
            if (op < 6)       wr("R10", a, d);
            else if (op < 8)  rd("R9", AW'($urandom_range(0, 3)));
            else              idle("R12", 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule